// File: doc/BRIEF.md
# Two-Wire Slave Switch-Enable Register

This block sits on a two-wire (I2C-compatible) bus as a slave device and owns an 8-bit register whose bits drive the enables of eight independent switches, one bit per switch, with a 1 closing the switch. Both bus lines are sampled with a fast system clock. Each line passes a noise filter before any bus event is decoded. The block never drives SDA high: it asserts an output-enable that the pad turns into a pull-down, and it never stretches SCL.

A master addresses the block with a 7-bit address. The upper five bits are fixed at `10010` and the lowest two come from strap pins. The address is followed by a direction bit. A write loads every following data byte into the register as soon as that byte completes, so several bytes in one transaction give several updates. A read returns the register contents, and it sends the same byte again for as long as the master keeps acknowledging.

Top module: `twowire_switch_ctrl`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits, sent MSB first, equal `1 0 0 1 0 sel[1] sel[0]`, by asserting `sda_oe` (SDA low) during the ninth SCL pulse. Bit 0 of the address byte selects the direction: 0 is write and 1 is read.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP the block releases SDA and waits for the next START.
- R3: `sda_oe` changes only while the filtered SCL is low. It never changes during an SCL high phase.
- R4: When the address does not match, the block gives no acknowledge and ignores all later bytes, leaving `sw_en` unchanged, until the next START.
- R5: In a write, each data byte (MSB first, bit 7 mapping to `sw_en[7]`) is acknowledged, and it is loaded into `sw_en` on the SCL falling edge that ends the byte's eighth bit. Each further byte before the STOP updates `sw_en` again.
- R6: In a read, the block drives the register MSB first on eight SCL pulses. If the master acknowledges (SDA low on the ninth pulse), the same byte is sent again. A master no-acknowledge ends the read and leaves SDA released.
- R7: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks does not change the filtered level, and so causes no bus event.
- R8: Synchronous reset clears `sw_en` to all zeros and releases SDA.
- R9: A START that arrives in the middle of a transaction drops the partial byte without touching `sw_en`, and it restarts address matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sel | input | 2 | Strap pins giving the two low address bits |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sw_en | output | 8 | Switch enables, one bit per switch |

## Verification
A corrupted byte-engine state shows up at SDA within one bus bit. It appears as a missing or misplaced acknowledge, or as a wrong bit in the readback byte. A bad receive shift shows up as a wrong `sw_en` value at the falling edge that closes the byte. A filter that passes short pulses adds a phantom SCL edge, and the register then holds a byte shifted by one bit position. A broken START or STOP decoder leaves SDA held low after the bus frees, or it makes the block answer the wrong address on the next transaction. The bench reads `sw_en` back through the bus after each abnormal sequence, and it watches `sda_oe` for changes during SCL high on every cycle.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
    localparam int SEL_W = 2;

    // Fixed upper part of the 7-bit device address
    localparam logic [4:0] DEV_ID_HI = 5'b10010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tw_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } tw_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] abyte,
                                      input logic [SEL_W-1:0] strap);
        return abyte[BYTE_W-1:1] == {DEV_ID_HI, strap};
    endfunction

endpackage

// File: rtl/tw_deglitch.sv
module tw_deglitch #(
    parameter int STABLE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(STABLE_CYC + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] != line_o) begin
                if (run_q == CNT_W'(STABLE_CYC - 1)) begin
                    line_o <= sync_q[1];
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events
    import tw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output tw_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.start = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop  = scl_f & scl_q & ~sda_q & sda_f;
        evt.rise  = scl_f & ~scl_q;
        evt.fall  = ~scl_f & scl_q;
    end
endmodule

// File: rtl/tw_byte_fsm.sv
module tw_byte_fsm
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tw_evt_t           evt,
    input  logic              sda_f,
    input  logic [SEL_W-1:0]  sel,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] sw_en
);
    tw_state_e            state;
    logic [BIT_CNT_W-1:0] nbits;
    logic [BYTE_W-1:0]    rx_sh;
    logic [BYTE_W-1:0]    tx_sh;
    logic                 dir_rd;
    logic                 m_ack;
    logic                 byte_done;

    assign byte_done = (nbits == BIT_CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            nbits  <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            dir_rd <= 1'b0;
            m_ack  <= 1'b0;
            sda_oe <= 1'b0;
            sw_en  <= '0;
        end else if (evt.start) begin
            state  <= ST_ADDR;
            nbits  <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (evt.rise) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], sda_f};
                        nbits <= nbits + 1'b1;
                    end else if (evt.fall && byte_done) begin
                        if (addr_hit(rx_sh, sel)) begin
                            state  <= ST_ADDR_ACK;
                            dir_rd <= rx_sh[0];
                            sda_oe <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.fall) begin
                        nbits <= '0;
                        if (dir_rd) begin
                            state  <= ST_RD;
                            tx_sh  <= sw_en;
                            sda_oe <= ~sw_en[BYTE_W-1];
                        end else begin
                            state  <= ST_WR;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (evt.rise) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], sda_f};
                        nbits <= nbits + 1'b1;
                    end else if (evt.fall && byte_done) begin
                        sw_en  <= rx_sh;
                        state  <= ST_WR_ACK;
                        sda_oe <= 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (evt.fall) begin
                        state  <= ST_WR;
                        nbits  <= '0;
                        sda_oe <= 1'b0;
                    end
                end
                ST_RD: begin
                    if (evt.rise) begin
                        nbits <= nbits + 1'b1;
                    end else if (evt.fall) begin
                        if (byte_done) begin
                            state  <= ST_RD_ACK;
                            sda_oe <= 1'b0;
                        end else begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (evt.rise) begin
                        m_ack <= ~sda_f;
                    end else if (evt.fall) begin
                        if (m_ack) begin
                            state  <= ST_RD;
                            nbits  <= '0;
                            tx_sh  <= sw_en;
                            sda_oe <= ~sw_en[BYTE_W-1];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/twowire_switch_ctrl.sv
module twowire_switch_ctrl
    import tw_pkg::*;
#(
    parameter int FILT_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  sel,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] sw_en
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic               scl_f, sda_f;
    tw_evt_t            evt;
    logic               start_evt, stop_evt, scl_fall_evt;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        tw_deglitch #(.STABLE_CYC(FILT_CYCLES)) u_flt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    assign scl_f = clean_lines[0];
    assign sda_f = clean_lines[1];

    tw_bus_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .evt   (evt)
    );

    assign start_evt    = evt.start;
    assign stop_evt     = evt.stop;
    assign scl_fall_evt = evt.fall;

    tw_byte_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .sda_f  (sda_f),
        .sel    (sel),
        .sda_oe (sda_oe),
        .sw_en  (sw_en)
    );
endmodule

// File: rtl/tw_switch_checker.sv
module tw_switch_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_f,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       scl_fall_evt,
    input logic       sda_oe,
    input logic [7:0] sw_en
);
    // R3: the slave never moves SDA while SCL stays high
    p_oe_steady_high_r3: assert property (@(posedge clk) disable iff (rst)
        (scl_f && $past(scl_f)) |-> $stable(sda_oe));

    // R5: the register only changes right after an SCL falling edge
    p_sw_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sw_en) |-> $past(scl_fall_evt));

    // R8: leaving reset, register cleared and SDA released
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sw_en == 8'h00 && !sda_oe));

    // R9: any START releases SDA
    p_start_release_r9: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !sda_oe);

    // R2: a STOP releases SDA
    p_stop_release_r2: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);
endmodule

bind twowire_switch_ctrl tw_switch_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_f        (scl_f),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .scl_fall_evt (scl_fall_evt),
    .sda_oe       (sda_oe),
    .sw_en        (sw_en)
);

// File: tb/sim_twowire_switch_ctrl.sv
`timescale 1ns/1ps
module sim_twowire_switch_ctrl;
    localparam int Q = 25;   // quarter SCL period in system clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       g_scl = 1'b0;
    logic [1:0] sel = 2'b10;
    logic       sda_oe;
    logic [7:0] sw_en;
    logic       scl_line, sda_line;

    int checks = 0;
    int fails  = 0;
    int r3_viol = 0;
    bit done = 0;

    assign scl_line = m_scl | g_scl;
    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    twowire_switch_ctrl u0 (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_line),
        .sda_i  (sda_line),
        .sel    (sel),
        .sda_oe (sda_oe),
        .sw_en  (sw_en)
    );

    // R3 monitor: SDA drive must hold while SCL stays high
    logic prev_scl = 1'b1;
    logic prev_oe  = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_line && prev_scl && (sda_oe != prev_oe))
            r3_viol++;
        prev_scl <= scl_line;
        prev_oe  <= sda_oe;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wait_clk(Q);
        m_scl = 1'b1; wait_clk(Q);
        m_sda = 1'b0; wait_clk(Q);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wait_clk(Q);
        m_scl = 1'b1; wait_clk(Q);
        m_sda = 1'b1; wait_clk(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    wait_clk(Q);
        m_scl = 1'b1; wait_clk(2*Q);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wait_clk(Q);
        m_scl = 1'b1; wait_clk(Q);
        acked = ~sda_line;
        wait_clk(Q);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q);
            m_scl = 1'b1; wait_clk(Q);
            d[i] = sda_line;
            wait_clk(Q);
            m_scl = 1'b0;
        end
        m_sda = ~give_ack; wait_clk(Q);
        m_scl = 1'b1; wait_clk(2*Q);
        m_scl = 1'b0; wait_clk(Q);
        m_sda = 1'b1;
    endtask

    task automatic t_reset;
        chk("R8 sw_en after reset", sw_en, 8'h00);
        chk("R8 sda released after reset", sda_oe, 1'b0);
    endtask

    task automatic t_single_write;
        logic a;
        bus_start;
        write_byte(8'h94, a);                 // 1001010, write
        chk("R1 address ack", a, 1'b1);
        write_byte(8'hA5, a);
        chk("R5 data ack", a, 1'b1);
        chk("R5 first byte loaded", sw_en, 8'hA5);
        bus_stop;
    endtask

    task automatic t_multi_write;
        logic a;
        bus_start;
        write_byte(8'h94, a);
        write_byte(8'h3C, a);
        chk("R5 byte 1 of burst", sw_en, 8'h3C);
        write_byte(8'hC3, a);
        chk("R5 byte 2 of burst", sw_en, 8'hC3);
        bus_stop;
        chk("R2 SDA released after STOP", sda_oe, 1'b0);
    endtask

    task automatic t_wrong_addr;
        logic a;
        bus_start;
        write_byte(8'h96, a);                 // low bits 11, strap is 10
        chk("R4 no ack on mismatch", a, 1'b0);
        write_byte(8'hFF, a);
        chk("R4 no ack on later byte", a, 1'b0);
        bus_stop;
        chk("R4 register untouched", sw_en, 8'hC3);
    endtask

    task automatic t_read;
        logic a;
        logic [7:0] d;
        bus_start;
        write_byte(8'h95, a);
        chk("R6 read address ack", a, 1'b1);
        read_byte(1'b1, d);
        chk("R6 first readback byte", d, 8'hC3);
        read_byte(1'b0, d);
        chk("R6 repeated byte after master ack", d, 8'hC3);
        chk("R6 SDA released after NACK", sda_oe, 1'b0);
        bus_stop;
    endtask

    task automatic t_restart;
        logic a;
        logic [7:0] d;
        bus_start;
        write_byte(8'h94, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start;                            // repeated START mid-byte
        write_byte(8'h95, a);
        chk("R9 address ack after restart", a, 1'b1);
        read_byte(1'b0, d);
        chk("R9 partial byte dropped", d, 8'hC3);
        bus_stop;
        chk("R9 register kept", sw_en, 8'hC3);
    endtask

    task automatic t_glitch;
        logic a;
        bus_start;
        write_byte(8'h94, a);
        m_sda = 1'b0; wait_clk(Q/2);
        g_scl = 1'b1; wait_clk(2);            // short spike on SCL
        g_scl = 1'b0; wait_clk(Q/2);
        m_scl = 1'b1; wait_clk(2*Q);
        m_scl = 1'b0; wait_clk(Q);
        for (int i = 6; i >= 0; i--) send_bit(i[0] ? 1'b1 : 1'b0); // 0x2A -> 0101010 after leading 0
        m_sda = 1'b1; wait_clk(Q);
        m_scl = 1'b1; wait_clk(Q);
        a = ~sda_line; wait_clk(Q);
        m_scl = 1'b0; wait_clk(Q);
        chk("R7 ack despite SCL spike", a, 1'b1);
        chk("R7 byte unshifted by spike", sw_en, 8'h2A);
        bus_stop;
    endtask

    task automatic t_strap;
        logic a;
        sel = 2'b01;
        wait_clk(4);
        bus_start;
        write_byte(8'h92, a);                 // 1001001, write
        chk("R1 ack with new strap", a, 1'b1);
        write_byte(8'h81, a);
        chk("R5 write with new strap", sw_en, 8'h81);
        bus_stop;
    endtask

    task automatic t_mid_reset;
        rst = 1'b1; wait_clk(3);
        rst = 1'b0; wait_clk(2);
        chk("R8 reset clears register", sw_en, 8'h00);
        chk("R8 reset releases SDA", sda_oe, 1'b0);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(10);
        t_reset;
        t_single_write;
        t_multi_write;
        t_wrong_addr;
        t_read;
        t_restart;
        t_glitch;
        t_strap;
        t_mid_reset;
        chk("R3 SDA drive steady during SCL high", r3_viol, 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule